// File: doc/BRIEF.md
# Local Interrupt Priority Selector

This block decides which local interrupt a hart should take next, if any. It receives the pending and enable vectors, a per-source delegation mask, the current privilege level, the machine and supervisor global interrupt-enable bits, a separate host supervisor enable, and a flag that says the hart is running a virtualized guest. From these it produces a valid flag, the cause number of the chosen source, and a flag that sends the trap to the host supervisor level instead of the guest.

Each global enable depends on the privilege level. A level below the enable's own level always accepts interrupts. At the enable's own level, its enable bit decides. Sources whose delegation bit is clear answer to the machine enable. Sources whose delegation bit is set answer to the supervisor enable. Three guest-level source positions (bits 2, 6 and 10) are held apart from the normal candidate set. In virtualized mode, a host-level source that passes the host supervisor enable wins before any guest source is considered. Among the sources that qualify, the lowest bit index wins. The decision is registered once, so the outputs follow the inputs by one clock.

Top module: `lirq_select`

## Requirements
- R1: A source is a candidate only if its bit is set in both `pend` and `enab`. A source whose enable bit is clear is never chosen.
- R2: The machine-level enable is true when `priv` (0 user, 1 supervisor, 3 machine) is below 3. It is also true when `priv` is 3 and `m_ie` is 1. With `priv`=3 and `m_ie`=0, no interrupt is reported.
- R3: The supervisor-level enable is true when `priv` is 0. It is also true when `priv` is 1 and `s_ie` is 1. With `priv` 2 or 3 it is false.
- R4: A source with its `deleg` bit clear is qualified by the machine-level enable. A source with its `deleg` bit set is qualified by the supervisor-level enable.
- R5: Among qualified sources, the lowest bit index is chosen and driven on `irq_cause`. With no qualified source, `irq_valid`, `irq_cause` and `force_host` are all 0.
- R6: When `virt`=0, the guest-level positions 2, 6 and 10 are never chosen, whatever their pending, enable and delegation bits.
- R7: When `virt`=1, the host enable is true when `priv` is 0, or when `priv` is 1 and `h_ie` is 1. A candidate outside positions 2, 6 and 10 that passes the host enable is chosen by lowest index ahead of every guest source, with `force_host`=1.
- R8: When `virt`=1 and no host candidate passes the host enable, only the guest positions 2, 6 and 10 are arbitrated under the R4 rules, with `force_host`=0. Host candidates that fail the host enable are ignored.
- R9: Outputs are registered: they reflect the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pend | input | 16 | Pending interrupt vector |
| enab | input | 16 | Interrupt enable vector |
| deleg | input | 16 | Delegation mask, 1 = handled at supervisor level |
| priv | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| m_ie | input | 1 | Machine global interrupt enable |
| s_ie | input | 1 | Supervisor global interrupt enable |
| h_ie | input | 1 | Host supervisor global interrupt enable (used when virtualized) |
| virt | input | 1 | Hart is running a virtualized guest |
| irq_valid | output | 1 | An interrupt is selected |
| irq_cause | output | 4 | Bit index of the selected source |
| force_host | output | 1 | Selected interrupt must be taken at host supervisor level |

## Verification
Every result is due exactly one rising edge after the inputs that produce it. No other latency exists, because the selection path has no state besides the output register. The driver applies a stimulus on a falling edge and queues the result it expects. The monitor takes one queued item just after the following rising edge and compares it with the outputs, so each comparison lines up with the cycle its stimulus was sampled in. Directed cases cover each enable, delegation and virtualization corner. A pseudo-random sweep then checks the lowest-index rule.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
   typedef enum logic [1:0] {
      LVL_USER  = 2'd0,
      LVL_SUPER = 2'd1,
      LVL_RSVD  = 2'd2,
      LVL_MACH  = 2'd3
   } lvl_e;
endpackage

// File: rtl/lirq_gate.sv
module lirq_gate
   import lirq_pkg::*;
(
   input  logic [1:0] priv,
   input  logic       m_ie,
   input  logic       s_ie,
   input  logic       h_ie,
   output logic       m_ok,
   output logic       s_ok,
   output logic       h_ok
);
   lvl_e lvl;
   assign lvl = lvl_e'(priv);

   always_comb begin
      m_ok = (lvl != LVL_MACH) || m_ie;
      s_ok = (lvl == LVL_USER) || ((lvl == LVL_SUPER) && s_ie);
      h_ok = (lvl == LVL_USER) || ((lvl == LVL_SUPER) && h_ie);
   end
endmodule

// File: rtl/lirq_qual.sv
module lirq_qual #(
   parameter int W = 16
) (
   input  logic [W-1:0] cand,
   input  logic [W-1:0] deleg,
   input  logic         m_ok,
   input  logic         s_ok,
   output logic [W-1:0] qual
);
   for (genvar g = 0; g < W; g++) begin : g_src
      assign qual[g] = cand[g] & (deleg[g] ? s_ok : m_ok);
   end
endmodule

// File: rtl/lirq_ctz.sv
module lirq_ctz #(
   parameter int W  = 16,
   parameter int CW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [CW-1:0] idx
);
   if (W < 2) begin : g_bad_w
      $error("lirq_ctz: W must be at least 2");
   end
   if (CW < $clog2(W)) begin : g_bad_cw
      $error("lirq_ctz: CW too narrow for W");
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = CW'(i);
         end
      end
   end
endmodule

// File: rtl/lirq_select.sv
module lirq_select #(
   parameter int               SRC_W      = 16,
   parameter int               CAUSE_W    = $clog2(SRC_W),
   parameter logic [SRC_W-1:0] GUEST_MASK = SRC_W'(16'h0444)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SRC_W-1:0]   pend,
   input  logic [SRC_W-1:0]   enab,
   input  logic [SRC_W-1:0]   deleg,
   input  logic [1:0]         priv,
   input  logic               m_ie,
   input  logic               s_ie,
   input  logic               h_ie,
   input  logic               virt,
   output logic               irq_valid,
   output logic [CAUSE_W-1:0] irq_cause,
   output logic               force_host
);
   localparam logic [SRC_W-1:0] HOST_MASK = ~GUEST_MASK;

   if (SRC_W < 2) begin : g_bad_src
      $error("lirq_select: SRC_W must be at least 2");
   end
   if (CAUSE_W < $clog2(SRC_W)) begin : g_bad_cause
      $error("lirq_select: CAUSE_W too narrow");
   end

   logic               m_ok, s_ok, h_ok;
   logic [SRC_W-1:0]   cand, host_c, guest_c, host_q, norm_c, norm_q;
   logic               host_found, norm_found;
   logic [CAUSE_W-1:0] host_idx, norm_idx;
   logic               nxt_valid, nxt_force;
   logic [CAUSE_W-1:0] nxt_cause;

   // R1: candidates require pending and enabled
   assign cand    = pend & enab;
   assign host_c  = cand & HOST_MASK;
   assign guest_c = cand & GUEST_MASK;
   assign host_q  = host_c & {SRC_W{h_ok & virt}};
   assign norm_c  = virt ? guest_c : host_c;

   lirq_gate u_gate (
      .priv (priv),
      .m_ie (m_ie),
      .s_ie (s_ie),
      .h_ie (h_ie),
      .m_ok (m_ok),
      .s_ok (s_ok),
      .h_ok (h_ok)
   );

   lirq_qual #(.W(SRC_W)) u_qual (
      .cand  (norm_c),
      .deleg (deleg),
      .m_ok  (m_ok),
      .s_ok  (s_ok),
      .qual  (norm_q)
   );

   lirq_ctz #(.W(SRC_W), .CW(CAUSE_W)) u_ctz_host (
      .vec   (host_q),
      .found (host_found),
      .idx   (host_idx)
   );

   lirq_ctz #(.W(SRC_W), .CW(CAUSE_W)) u_ctz_norm (
      .vec   (norm_q),
      .found (norm_found),
      .idx   (norm_idx)
   );

   always_comb begin
      nxt_force = host_found;
      nxt_valid = host_found | norm_found;
      nxt_cause = host_found ? host_idx : (norm_found ? norm_idx : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_cause  <= '0;
         force_host <= 1'b0;
      end else begin
         irq_valid  <= nxt_valid;
         irq_cause  <= nxt_cause;
         force_host <= nxt_force;
      end
   end

   // R1
   pick_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> ((((($past(pend) & $past(enab)) >> irq_cause)) & SRC_W'(1)) != '0));

   // R2
   mmode_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> !(($past(priv) == 2'd3) && !$past(m_ie)));

   // R5
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> ((irq_cause == '0) && !force_host));

   // R6
   no_guest_native_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !$past(virt)) |-> !GUEST_MASK[irq_cause]);

   // R7
   force_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_host |-> ($past(virt) && irq_valid && !GUEST_MASK[irq_cause]));
endmodule

// File: tb/lirq_select_test.sv
module lirq_select_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pend = '0, enab = '0, deleg = '0;
   logic [1:0]  priv = '0;
   logic        m_ie = 1'b0, s_ie = 1'b0, h_ie = 1'b0, virt = 1'b0;
   logic        irq_valid, force_host;
   logic [3:0]  irq_cause;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct {
      logic       v;
      logic       f;
      logic [3:0] c;
      string      tag;
   } exp_t;

   exp_t q[$];

   always #2 clk = ~clk;

   lirq_select uut (
      .clk(clk), .rst_n(rst_n), .pend(pend), .enab(enab), .deleg(deleg),
      .priv(priv), .m_ie(m_ie), .s_ie(s_ie), .h_ie(h_ie), .virt(virt),
      .irq_valid(irq_valid), .irq_cause(irq_cause), .force_host(force_host)
   );

   localparam logic [15:0] GUEST = 16'h0444;

   function automatic exp_t model(input logic [15:0] p, e, d, input logic [1:0] pr,
                                  input logic mi, si, hi, vi);
      exp_t r;
      logic [15:0] c, pool;
      logic mok, sok, hok, hit;
      r.v = 0; r.f = 0; r.c = 0; r.tag = "";
      c   = p & e;
      mok = (pr != 2'd3) || mi;
      sok = (pr == 2'd0) || (pr == 2'd1 && si);
      hok = (pr == 2'd0) || (pr == 2'd1 && hi);
      hit = 0;
      if (vi && hok) begin
         for (int i = 0; i < 16; i++)
            if (!hit && c[i] && !GUEST[i]) begin hit = 1; r.v = 1; r.f = 1; r.c = 4'(i); end
      end
      if (!hit) begin
         pool = vi ? (c & GUEST) : (c & ~GUEST);
         for (int i = 0; i < 16; i++)
            if (!hit && pool[i] && (d[i] ? sok : mok)) begin hit = 1; r.v = 1; r.c = 4'(i); end
      end
      return r;
   endfunction

   task automatic drive(input logic [15:0] p, e, d, input logic [1:0] pr,
                        input logic mi, si, hi, vi, input string tag);
      exp_t x;
      @(negedge clk);
      pend = p; enab = e; deleg = d; priv = pr;
      m_ie = mi; s_ie = si; h_ie = hi; virt = vi;
      x = model(p, e, d, pr, mi, si, hi, vi);
      x.tag = tag;
      q.push_back(x);
   endtask

   // monitor: result due one rising edge after the driving falling edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t x;
         x = q.pop_front();
         total++;
         if (irq_valid !== x.v || irq_cause !== x.c || force_host !== x.f) begin
            bad++;
            $display("FAIL %s: got v=%0b c=%0d f=%0b expected v=%0b c=%0d f=%0b",
                     x.tag, irq_valid, irq_cause, force_host, x.v, x.c, x.f);
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R9: outputs stay zero in reset even with a qualifying input
      pend = 16'h0080; enab = 16'h0080; priv = 2'd3; m_ie = 1'b1;
      repeat (3) @(negedge clk);
      total++;
      if (irq_valid !== 1'b0 || irq_cause !== 4'd0 || force_host !== 1'b0) begin
         bad++;
         $display("FAIL R9 reset: got v=%0b c=%0d f=%0b expected 0 0 0",
                  irq_valid, irq_cause, force_host);
      end
      rst_n = 1'b1;

      // R2 machine enable
      drive(16'h0080, 16'h0080, 16'h0000, 2'd3, 1, 0, 0, 0, "R2 m-level on");
      drive(16'h0080, 16'h0080, 16'h0000, 2'd3, 0, 0, 0, 0, "R2 m-level off");
      drive(16'h0080, 16'h0080, 16'h0000, 2'd1, 0, 0, 0, 0, "R2 below machine");
      // R3 supervisor enable on delegated source
      drive(16'h0080, 16'h0080, 16'h0080, 2'd1, 1, 0, 0, 0, "R3 s-level off");
      drive(16'h0080, 16'h0080, 16'h0080, 2'd1, 1, 1, 0, 0, "R3 s-level on");
      drive(16'h0080, 16'h0080, 16'h0080, 2'd0, 0, 0, 0, 0, "R3 user level");
      drive(16'h0080, 16'h0080, 16'h0080, 2'd2, 1, 1, 0, 0, "R3 reserved level");
      drive(16'h0080, 16'h0080, 16'h0080, 2'd3, 1, 1, 0, 0, "R4 delegated at machine");
      // R1 enable mask
      drive(16'h0880, 16'h0800, 16'h0000, 2'd3, 1, 0, 0, 0, "R1 disabled lower bit");
      drive(16'hFFFF, 16'h0000, 16'h0000, 2'd0, 1, 1, 1, 0, "R1 all disabled");
      // R5 lowest index, R4 split qualification
      drive(16'h8882, 16'hFFFF, 16'h0000, 2'd3, 1, 0, 0, 0, "R5 lowest index");
      drive(16'h0022, 16'hFFFF, 16'h0002, 2'd3, 1, 1, 0, 0, "R4 mixed delegation");
      drive(16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1, 1, 1, 0, "R5 none pending");
      // R6 guest positions excluded natively
      drive(16'h0444, 16'hFFFF, 16'h0000, 2'd0, 1, 1, 1, 0, "R6 guest only");
      drive(16'h0448, 16'hFFFF, 16'h0444, 2'd0, 1, 1, 1, 0, "R6 guest skipped");
      // R7 host first under virtualization
      drive(16'h0024, 16'hFFFF, 16'h0000, 2'd1, 1, 1, 1, 1, "R7 host ahead of guest");
      drive(16'h8004, 16'hFFFF, 16'h0000, 2'd0, 0, 0, 0, 1, "R7 user level host");
      // R8 guest arbitration
      drive(16'h0024, 16'hFFFF, 16'h0004, 2'd1, 1, 1, 0, 1, "R8 guest delegated");
      drive(16'h0024, 16'hFFFF, 16'h0000, 2'd1, 0, 0, 0, 1, "R8 guest via machine");
      drive(16'h0020, 16'hFFFF, 16'h0000, 2'd1, 1, 1, 0, 1, "R8 host ignored");
      drive(16'h0440, 16'hFFFF, 16'h0400, 2'd3, 1, 1, 1, 1, "R8 machine level virt");
      // R5 sweep
      for (int k = 0; k < 300; k++) begin
         drive(16'($urandom), 16'($urandom), 16'($urandom), 2'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R5 sweep");
      end
      while (q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule